// File: doc/BRIEF.md
# Load Result Shaper

This block sits at the end of a fixed-point load path. It receives the raw bytes that memory returned for one access and turns them into the 64-bit value written to the destination register. Each request carries an access size of one, two, four or eight bytes, a sign-extension choice and a byte-reverse choice. The bytes arrive right-justified in big-endian order, so the byte from the lowest address is the most significant byte of the accessed field.

Narrow loads either zero-fill or sign-fill the upper bits. Doubleword loads pass through unchanged. Byte-reversed loads flip the order of the accessed bytes and always zero-fill the upper bits. A reversed load cannot also ask for sign extension or be one byte wide. Such a request is rejected: the block raises an error flag and returns zero. The output has one register stage, and a valid strobe travels alongside the data.

Top module: `load_result_shaper`

## Requirements
- R1: With signExt=0, byteRev=0 and accSize 2'b00 (1 byte), 2'b01 (2 bytes) or 2'b10 (4 bytes), the accessed field appears in the low bits of result and every bit above it is 0.
- R2: With signExt=1, byteRev=0 and a 1-, 2- or 4-byte size, every bit of result above the accessed field equals the most significant bit of that field.
- R3: With accSize 2'b11 (8 bytes) and byteRev=0, result equals memData in all 64 bits, whatever signExt is.
- R4: For an access of N bytes, the data is taken from memData[8N-1:0]. The lowest-address byte is memData[8N-1:8N-8]. Bits of memData above 8N have no effect on result.
- R5: With byteRev=1, signExt=0 and a 2- or 4-byte size, result holds the accessed bytes in reversed order and all bits above the field are 0. The lowest-address byte lands in result[7:0].
- R6: With byteRev=1, signExt=0 and the 8-byte size, all eight bytes are reversed: memData[63:56] lands in result[7:0] and memData[7:0] lands in result[63:56].
- R7: A request with byteRev=1 that also has signExt=1 or the 1-byte size sets illegal=1 and result=0. Every other request sets illegal=0.
- R8: outValid is high exactly one clock after a cycle in which inValid is high. result and illegal take the new value on that same clock.
- R9: After reset, outValid, result and illegal are 0. While inValid is low, result and illegal hold their last value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Request present this cycle |
| accSize | input | 2 | Access size: 00=1, 01=2, 10=4, 11=8 bytes |
| signExt | input | 1 | 1 selects sign extension |
| byteRev | input | 1 | 1 selects byte-reversed order |
| memData | input | 64 | Returned bytes, right-justified, big-endian |
| outValid | output | 1 | Registered result is new |
| result | output | 64 | Formatted register value |
| illegal | output | 1 | Request was an illegal combination |

## Verification
The bench fills the unused upper bits of memData with nonzero patterns. A design that takes the field from the wrong bytes, or lets stray bits leak through, therefore shows garbage above the field. Sign-extension cases use field values with the top bit set and with it clear. This catches a design that tests the wrong bit, fills from the wrong byte, or extends doublewords. Reversed loads use distinct bytes in every lane, so any swap or off-by-one in the mirroring shows up in the checked value. The bench also covers each illegal combination, back-to-back requests, idle cycles that must hold the output, and a reset in the middle of traffic. These catch a design that lets a rejected request through, drops a pipelined result, or loses the held value.

// File: rtl/ldshape_pkg.sv
package ldshape_pkg;
  parameter int DATA_W = 64;
  parameter int LANE_W = 8;
  localparam int LANES = DATA_W / LANE_W;
  localparam int IDX_W = $clog2(LANES);

  typedef enum logic [1:0] {
    SZ_BYTE  = 2'b00,
    SZ_HALF  = 2'b01,
    SZ_WORD  = 2'b10,
    SZ_DWORD = 2'b11
  } accSize_e;

  // strobes passed from the decoder to the datapath
  typedef struct packed {
    logic             load;     // capture a new result
    logic             reject;   // illegal combination, force zero
    logic             reverse;  // mirror lanes inside the field
    logic             extend;   // fill upper lanes with the sign bit
    logic [IDX_W-1:0] topLane;  // index of the highest lane in the field
    logic [LANES-1:0] laneKeep; // lanes that belong to the field
  } shapeCtrl_t;
endpackage

// File: rtl/ldshape_ctrl.sv
module ldshape_ctrl
  import ldshape_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] accSize,
  input  logic       signExt,
  input  logic       byteRev,
  output shapeCtrl_t ctrl
);
  accSize_e sizeSel;
  logic [IDX_W-1:0] topIdx;

  always_comb begin
    sizeSel = accSize_e'(accSize);
    unique case (sizeSel)
      SZ_BYTE:  topIdx = IDX_W'(0);
      SZ_HALF:  topIdx = IDX_W'(1);
      SZ_WORD:  topIdx = IDX_W'(3);
      default:  topIdx = IDX_W'(LANES - 1);
    endcase
  end

  for (genvar i = 0; i < LANES; i++) begin : g_keep
    assign ctrl.laneKeep[i] = (IDX_W'(i) <= topIdx);
  end

  assign ctrl.load    = inValid;
  assign ctrl.topLane = topIdx;
  assign ctrl.reject  = byteRev && (signExt || (sizeSel == SZ_BYTE));
  assign ctrl.reverse = byteRev;
  assign ctrl.extend  = signExt && !byteRev && (sizeSel != SZ_DWORD);
endmodule

// File: rtl/ldshape_dp.sv
module ldshape_dp
  import ldshape_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  shapeCtrl_t        ctrl,
  input  logic [DATA_W-1:0] memData,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  logic              signBit;
  logic [LANE_W-1:0] fillByte;
  logic [DATA_W-1:0] shaped;
  logic [DATA_W-1:0] nextResult;

  assign signBit  = memData[ctrl.topLane * LANE_W + (LANE_W - 1)];
  assign fillByte = ctrl.extend ? {LANE_W{signBit}} : '0;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic [IDX_W-1:0] srcIdx;
    assign srcIdx = ctrl.reverse ? (ctrl.topLane - IDX_W'(i)) : IDX_W'(i);
    assign shaped[i*LANE_W +: LANE_W] =
      ctrl.laneKeep[i] ? memData[srcIdx * LANE_W +: LANE_W] : fillByte;
  end

  assign nextResult = ctrl.reject ? '0 : shaped;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      result   <= '0;
      illegal  <= 1'b0;
    end else begin
      outValid <= ctrl.load;
      if (ctrl.load) begin
        result  <= nextResult;
        illegal <= ctrl.reject;
      end
    end
  end

  a_r8_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    ctrl.load |=> outValid);
  a_r8_idle_drops: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> !outValid);
  a_r7_reject_zero: assert property (@(posedge clk) disable iff (!rstN)
    illegal |-> (result == '0));
  a_r9_hold_idle: assert property (@(posedge clk) disable iff (!rstN)
    !ctrl.load |=> ($stable(result) && $stable(illegal)));
endmodule

// File: rtl/load_result_shaper.sv
module load_result_shaper
  import ldshape_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              inValid,
  input  logic [1:0]        accSize,
  input  logic              signExt,
  input  logic              byteRev,
  input  logic [DATA_W-1:0] memData,
  output logic              outValid,
  output logic [DATA_W-1:0] result,
  output logic              illegal
);
  shapeCtrl_t ctrl;

  ldshape_ctrl u_ctrl (
    .inValid (inValid),
    .accSize (accSize),
    .signExt (signExt),
    .byteRev (byteRev),
    .ctrl    (ctrl)
  );

  ldshape_dp u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .ctrl     (ctrl),
    .memData  (memData),
    .outValid (outValid),
    .result   (result),
    .illegal  (illegal)
  );

  a_r1_byte_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !signExt && !byteRev && accSize == 2'b00)
      |=> (result[DATA_W-1:LANE_W] == '0));
  a_r3_dword_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !byteRev && accSize == 2'b11) |=> (result == $past(memData)));
  a_r5_rev_upper_clear: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && byteRev && accSize != 2'b11)
      |=> (result[DATA_W-1:DATA_W/2] == '0));
  a_r7_flag_matches: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && byteRev && (signExt || accSize == 2'b00)) |=> illegal);
endmodule

// File: tb/sim_load_result_shaper.sv
`timescale 1ns/1ps
module sim_load_result_shaper;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic [1:0]  accSize = 2'b00;
  logic        signExt = 1'b0;
  logic        byteRev = 1'b0;
  logic [63:0] memData = '0;
  logic        outValid;
  logic [63:0] result;
  logic        illegal;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  always #5 clk = ~clk;

  load_result_shaper u0 (
    .clk(clk), .rstN(rstN), .inValid(inValid), .accSize(accSize),
    .signExt(signExt), .byteRev(byteRev), .memData(memData),
    .outValid(outValid), .result(result), .illegal(illegal)
  );

  // {req[3:0], size[1:0], sign, rev, data[63:0], expected[63:0], expIllegal}
  localparam int NV = 16;
  localparam logic [136:0] VEC [NV] = '{
    {4'd1, 2'b00, 1'b0, 1'b0, 64'hAAAA_AAAA_AAAA_AA85, 64'h0000_0000_0000_0085, 1'b0}, // R1 R4
    {4'd2, 2'b00, 1'b1, 1'b0, 64'hAAAA_AAAA_AAAA_AA85, 64'hFFFF_FFFF_FFFF_FF85, 1'b0}, // R2
    {4'd2, 2'b00, 1'b1, 1'b0, 64'hFFFF_FFFF_FFFF_FF7F, 64'h0000_0000_0000_007F, 1'b0}, // R2 R4
    {4'd1, 2'b01, 1'b0, 1'b0, 64'h1111_1111_1111_8001, 64'h0000_0000_0000_8001, 1'b0}, // R1
    {4'd2, 2'b01, 1'b1, 1'b0, 64'h1111_1111_1111_8001, 64'hFFFF_FFFF_FFFF_8001, 1'b0}, // R2
    {4'd1, 2'b10, 1'b0, 1'b0, 64'hDEAD_BEEF_8765_4321, 64'h0000_0000_8765_4321, 1'b0}, // R1 R4
    {4'd2, 2'b10, 1'b1, 1'b0, 64'hDEAD_BEEF_8765_4321, 64'hFFFF_FFFF_8765_4321, 1'b0}, // R2
    {4'd2, 2'b10, 1'b1, 1'b0, 64'hFFFF_FFFF_7FFF_FFFF, 64'h0000_0000_7FFF_FFFF, 1'b0}, // R2
    {4'd3, 2'b11, 1'b0, 1'b0, 64'h0123_4567_89AB_CDEF, 64'h0123_4567_89AB_CDEF, 1'b0}, // R3
    {4'd3, 2'b11, 1'b1, 1'b0, 64'hFEDC_BA98_7654_3210, 64'hFEDC_BA98_7654_3210, 1'b0}, // R3
    {4'd5, 2'b01, 1'b0, 1'b1, 64'hFFFF_FFFF_FFFF_A1B2, 64'h0000_0000_0000_B2A1, 1'b0}, // R5
    {4'd5, 2'b10, 1'b0, 1'b1, 64'h9999_9999_1122_3344, 64'h0000_0000_4433_2211, 1'b0}, // R5
    {4'd6, 2'b11, 1'b0, 1'b1, 64'h0123_4567_89AB_CDEF, 64'hEFCD_AB89_6745_2301, 1'b0}, // R6
    {4'd7, 2'b01, 1'b1, 1'b1, 64'h0000_0000_0000_A1B2, 64'h0,                   1'b1}, // R7
    {4'd7, 2'b00, 1'b0, 1'b1, 64'h0000_0000_0000_00C3, 64'h0,                   1'b1}, // R7
    {4'd7, 2'b11, 1'b1, 1'b1, 64'h0123_4567_89AB_CDEF, 64'h0,                   1'b1}  // R7
  };

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] sz, input logic sg, input logic rv, input logic [63:0] d);
    inValid = 1'b1; accSize = sz; signExt = sg; byteRev = rv; memData = d;
  endtask

  initial begin
    #2_000_000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog: actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] held;
    repeat (3) @(negedge clk);
    // R9: reset state
    check("R9 reset outValid", {63'b0, outValid}, 64'd0);
    check("R9 reset result", result, 64'd0);
    check("R9 reset illegal", {63'b0, illegal}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    // table walk: drive at negedge, result registered at next posedge
    for (int k = 0; k < NV; k++) begin
      drive(VEC[k][132:131], VEC[k][130], VEC[k][129], VEC[k][128:65]);
      @(negedge clk);
      inValid = 1'b0;
      check($sformatf("R%0d vec%0d result", VEC[k][136:133], k), result, VEC[k][64:1]);
      check($sformatf("R7 vec%0d illegal", k), {63'b0, illegal}, {63'b0, VEC[k][0]});
      check($sformatf("R8 vec%0d outValid", k), {63'b0, outValid}, 64'd1);
    end

    // R9: idle cycles with changing inputs must hold the output
    held = result;
    drive(2'b11, 1'b0, 1'b0, 64'h5555_5555_5555_5555);
    inValid = 1'b0;
    @(negedge clk);
    check("R8 idle outValid", {63'b0, outValid}, 64'd0);
    memData = 64'h1234_0000_0000_0000;
    @(negedge clk);
    check("R9 hold result", result, held);
    check("R9 hold illegal", {63'b0, illegal}, 64'd1);

    // R8: back-to-back requests
    drive(2'b01, 1'b0, 1'b0, 64'h0000_0000_0000_BEEF);
    @(negedge clk);
    check("R8 b2b first", result, 64'h0000_0000_0000_BEEF);
    check("R7 b2b first illegal", {63'b0, illegal}, 64'd0);
    drive(2'b10, 1'b0, 1'b1, 64'h0000_0000_A0B0_C0D0);
    @(negedge clk);
    inValid = 1'b0;
    check("R8 b2b second", result, 64'h0000_0000_D0C0_B0A0);
    check("R8 b2b valid", {63'b0, outValid}, 64'd1);
    @(negedge clk);
    check("R8 b2b drop", {63'b0, outValid}, 64'd0);

    // R9: reset mid-traffic clears state
    drive(2'b11, 1'b0, 1'b0, 64'hFFFF_FFFF_FFFF_FFFF);
    rstN = 1'b0;
    @(negedge clk);
    inValid = 1'b0;
    check("R9 midreset result", result, 64'd0);
    check("R9 midreset valid", {63'b0, outValid}, 64'd0);
    rstN = 1'b1;
    @(negedge clk);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule